// File: doc/BRIEF.md
# TPM FIFO Register File

This block holds the byte-wide register space of a TPM that sits behind a low-pin-count bus target and runs on that bus clock. It decodes a 16-bit address into five locality windows. It tracks which locality owns the device and runs the command state machine. Command bytes go into a byte-addressed buffer RAM, and response bytes are streamed back out of it. It also raises a level interrupt toward the host.

On the firmware side, a finished command is handed over as an operation code, a locality and a byte length, qualified by a one-cycle execute strobe. Firmware signals completion with a pulse on `complete_i` and supplies the response length on `rsp_len_i`. The pulse may last any number of cycles, because only its rising edge is used. A host cancel request during execution shows up as a level on `abort_o`.

The bus side works through a request/acknowledge pair for each direction. Any request is accepted on the first clock edge that sees it. The acknowledge and the read data appear together one clock later, so no wait states are ever needed.

Top module: `tpm_fifo_regfile`

## Requirements
- R1: After reset: the ACCESS register (offset 0x000) of every locality reads 0x80; op_type_o, exec_o, abort_o, irq_o, wr_ack_o and rd_ack_o are all 0.
- R2: A request is accepted on the first rising edge that sees it. rd_ack_o/wr_ack_o go high on that edge, and rdata_o is valid with rd_ack_o. Both stay stable until the request drops, and the acknowledge falls one edge after the request falls.
- R3: A read of any address outside the defined registers returns 0xFF and has no effect. This covers bit 15 set, locality field 5 to 7, and an offset not listed here. A write to such an address changes nothing.
- R4: Locality n lives at n×0x1000 and its locality field is address bits 14:12. Writing bit 1 of ACCESS claims the device only if no locality holds it. Writing bit 5 of ACCESS from the owner releases it. ACCESS reads 0xA0 for the owner and 0x80 for every other locality.
- R5: STS (offset 0x018) and the FIFO (offset 0x024) read 0xFF from a non-owner locality, and writes to them from a non-owner are dropped.
- R6: STS reads {valid=1, cmdReady, 0, dataAvail, expect, 000}. Writing bit 6 in idle, reception or completion enters the ready state, where STS reads 0xC8. In idle, STS reads 0x80.
- R7: FIFO writes in the ready or reception state store bytes at buffer addresses 0, 1, 2 and so on, and the state becomes reception. The big-endian size in command bytes 2..5 is captured. expect (STS bit 3) stays 1 while fewer than 6 bytes, or fewer than that size, have been written.
- R8: Writing STS bit 5 in reception moves to execution and pulses exec_o for one cycle. At that point op_type_o is 1, locality_o is the owner and buf_len_o is the byte count.
- R9: Writing STS bit 6 during execution raises abort_o, which stays high until completion.
- R10: A rising edge of complete_i in execution enters completion. op_type_o returns to 0 and abort_o clears. FIFO reads return the response bytes from address 0 in order, with dataAvail (STS bit 4) set until rsp_len_i bytes have been read. After that, STS reads 0x80 and the FIFO reads 0xFF.
- R11: INT_ENABLE (0x008, bit 7 global, bit 0 data-available), INT_VECTOR (0x00C, bits 3:0 drive irq_num_o) and INT_STATUS (0x010, bit 0) can be read from any locality and written only by the owner. Entering completion sets INT_STATUS bit 0, and writing 1 to that bit clears it. irq_o is the AND of both enables and the status bit.
- R12: Writing STS bit 6 in completion returns to ready and clears dataAvail.
- R13: FIFO writes past the buffer capacity (2^BUF_AW bytes) are dropped, so buf_len_o never exceeds the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data from bus target |
| wr_req_i | input | 1 | Write request, held until acknowledged |
| wr_ack_o | output | 1 | Write acknowledge |
| rd_req_i | input | 1 | Read request, held until acknowledged |
| rd_ack_o | output | 1 | Read acknowledge, rdata_o valid |
| rdata_o | output | 8 | Read data to bus target |
| irq_num_o | output | 4 | Host interrupt number |
| irq_o | output | 1 | Host interrupt request, level |
| op_type_o | output | 4 | Operation code for firmware (0 none, 1 execute) |
| locality_o | output | 3 | Locality that issued the operation |
| buf_len_o | output | BUF_AW+1 | Command length in bytes |
| exec_o | output | 1 | One-cycle execute strobe |
| abort_o | output | 1 | Cancel requested by host |
| complete_i | input | 1 | Completion pulse from firmware |
| rsp_len_i | input | BUF_AW+1 | Response length in bytes |
| ram_addr_o | output | BUF_AW | Buffer byte address |
| ram_wdata_o | output | 8 | Buffer write data |
| ram_wr_o | output | 1 | Buffer write strobe |
| ram_rdata_i | input | 8 | Buffer read data (one-cycle latency) |

## Verification
The bench keeps the default five localities and builds the block with BUF_AW=5, which gives a 32-byte buffer. With that size, a 34-byte command is enough to reach the capacity limit, so the dropped-write boundary and the saturated length are checked in a few dozen cycles. The bench's own RAM model lets it preload response bytes and inspect command bytes without reaching into the design.

// File: rtl/tpm_fifo_regfile.sv
module tpm_fifo_regfile #(
  parameter int          NUM_LOC   = 5,
  parameter int          BUF_AW    = 12,
  parameter logic [7:0]  IDLE_DATA = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_req_i,
  output logic              wr_ack_o,
  input  logic              rd_req_i,
  output logic              rd_ack_o,
  output logic [7:0]        rdata_o,
  output logic [3:0]        irq_num_o,
  output logic              irq_o,
  output logic [3:0]        op_type_o,
  output logic [2:0]        locality_o,
  output logic [BUF_AW:0]   buf_len_o,
  output logic              exec_o,
  output logic              abort_o,
  input  logic              complete_i,
  input  logic [BUF_AW:0]   rsp_len_i,
  output logic [BUF_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              ram_wr_o,
  input  logic [7:0]        ram_rdata_i
);
  localparam int CW = BUF_AW + 1;
  localparam logic [CW-1:0] BUF_BYTES = CW'(1) << BUF_AW;
  localparam logic [3:0] OP_NONE = 4'd0;
  localparam logic [3:0] OP_EXEC = 4'd1;

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RX, S_EXEC, S_CPL} cmd_state_t;

  cmd_state_t        state;
  logic [NUM_LOC-1:0] act_q;
  logic [CW-1:0]     wr_cnt, rd_cnt, rsp_len;
  logic [31:0]       cmd_size;
  logic              gie, dav_en, ist, cpl_d;
  logic [3:0]        ivec;

  logic [2:0]  loc;
  logic [11:0] off;
  logic        loc_ok, is_act;
  logic [7:0]  act8;
  logic        hit_acc, hit_ien, hit_ivec, hit_ist, hit_sts, hit_fifo;
  logic        wr_go, rd_go, dav, expect_more, fifo_wr, cpl_edge;
  logic [7:0]  rd_val;

  assign loc      = addr_i[14:12];
  assign off      = addr_i[11:0];
  assign loc_ok   = !addr_i[15] && (32'(loc) < NUM_LOC);
  assign act8     = 8'(act_q);
  assign is_act   = loc_ok && act8[loc];
  assign hit_acc  = loc_ok && off == 12'h000;
  assign hit_ien  = loc_ok && off == 12'h008;
  assign hit_ivec = loc_ok && off == 12'h00C;
  assign hit_ist  = loc_ok && off == 12'h010;
  assign hit_sts  = loc_ok && off == 12'h018;
  assign hit_fifo = loc_ok && off == 12'h024;

  assign wr_go    = wr_req_i && !wr_ack_o;
  assign rd_go    = rd_req_i && !rd_ack_o;
  assign cpl_edge = complete_i && !cpl_d;

  assign dav         = state == S_CPL && rd_cnt < rsp_len;
  assign expect_more = state == S_READY ||
                       (state == S_RX && (wr_cnt < CW'(6) || 32'(wr_cnt) < cmd_size));

  assign fifo_wr = wr_go && hit_fifo && is_act &&
                   (state == S_READY || state == S_RX) && wr_cnt < BUF_BYTES;

  assign ram_wr_o    = fifo_wr;
  assign ram_wdata_o = wdata_i;
  assign ram_addr_o  = (state == S_CPL) ? rd_cnt[BUF_AW-1:0] : wr_cnt[BUF_AW-1:0];

  assign irq_o     = gie && dav_en && ist;
  assign irq_num_o = ivec;

  always_comb begin
    rd_val = IDLE_DATA;
    if (hit_acc)                 rd_val = {2'b10, is_act, 5'b0};
    else if (hit_ien)            rd_val = {gie, 6'b0, dav_en};
    else if (hit_ivec)           rd_val = {4'b0, ivec};
    else if (hit_ist)            rd_val = {7'b0, ist};
    else if (hit_sts && is_act)  rd_val = {1'b1, state == S_READY, 1'b0, dav, expect_more, 3'b0};
    else if (hit_fifo && is_act && dav) rd_val = ram_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_IDLE;
      act_q      <= '0;
      wr_cnt     <= '0;
      rd_cnt     <= '0;
      rsp_len    <= '0;
      cmd_size   <= '0;
      gie        <= 1'b0;
      dav_en     <= 1'b0;
      ist        <= 1'b0;
      ivec       <= '0;
      cpl_d      <= 1'b0;
      wr_ack_o   <= 1'b0;
      rd_ack_o   <= 1'b0;
      rdata_o    <= '0;
      op_type_o  <= OP_NONE;
      locality_o <= '0;
      buf_len_o  <= '0;
      exec_o     <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      exec_o   <= 1'b0;
      wr_ack_o <= wr_req_i;
      rd_ack_o <= rd_req_i;
      cpl_d    <= complete_i;

      if (rd_go) begin
        rdata_o <= rd_val;
        if (hit_fifo && is_act && dav) rd_cnt <= rd_cnt + 1'b1;
      end

      if (wr_go) begin
        if (hit_acc) begin
          if (wdata_i[1] && act_q == '0)  act_q <= NUM_LOC'(1) << loc;
          else if (wdata_i[5] && is_act)  act_q <= '0;
        end
        if (is_act && hit_ien) begin
          gie    <= wdata_i[7];
          dav_en <= wdata_i[0];
        end
        if (is_act && hit_ivec) ivec <= wdata_i[3:0];
        if (is_act && hit_ist && wdata_i[0]) ist <= 1'b0;
        if (is_act && hit_sts) begin
          if (wdata_i[6]) begin
            if (state == S_EXEC) abort_o <= 1'b1;
            else begin
              state    <= S_READY;
              wr_cnt   <= '0;
              cmd_size <= '0;
            end
          end else if (wdata_i[5] && state == S_RX) begin
            state      <= S_EXEC;
            exec_o     <= 1'b1;
            op_type_o  <= OP_EXEC;
            locality_o <= loc;
            buf_len_o  <= wr_cnt;
          end
        end
        if (is_act && hit_fifo && (state == S_READY || state == S_RX)) begin
          state <= S_RX;
          if (fifo_wr) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (wr_cnt >= CW'(2) && wr_cnt <= CW'(5)) cmd_size <= {cmd_size[23:0], wdata_i};
          end
        end
      end

      if (state == S_EXEC && cpl_edge) begin
        state     <= S_CPL;
        rsp_len   <= rsp_len_i;
        rd_cnt    <= '0;
        abort_o   <= 1'b0;
        op_type_o <= OP_NONE;
        ist       <= 1'b1;
      end
    end
  end

  p_one_owner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q));

  p_rdata_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o && $past(rd_ack_o) |-> $stable(rdata_o));

  p_exec_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);

  p_exec_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> op_type_o == OP_EXEC);

  p_abort_in_exec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> op_type_o == OP_EXEC);

  p_cpl_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_CPL |-> op_type_o == OP_NONE && !abort_o);

  p_len_cap_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt <= BUF_BYTES && buf_len_o <= BUF_BYTES);
endmodule

// File: tb/tpm_fifo_regfile_tb.sv
module tpm_fifo_regfile_tb;
  localparam int AW = 5;
  localparam int CW = AW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr_req = 1'b0, rd_req = 1'b0, complete = 1'b0;
  logic [CW-1:0] rsp_len = '0;
  logic wr_ack, rd_ack, irq, exec_s, abort_s, ram_wr;
  logic [7:0] rdata, ram_wdata;
  logic [7:0] ram_rdata = '0;
  logic [3:0] irq_num, op_type;
  logic [2:0] locality;
  logic [CW-1:0] buf_len;
  logic [AW-1:0] ram_addr;
  logic [7:0] mem [0:(1<<AW)-1];

  int checks = 0, errors = 0, cycles = 0, exec_cnt = 0;
  logic [3:0] cap_op;
  logic [2:0] cap_loc;
  logic [CW-1:0] cap_len;

  tpm_fifo_regfile #(.NUM_LOC(5), .BUF_AW(AW), .IDLE_DATA(8'hFF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_req_i(wr_req), .wr_ack_o(wr_ack), .rd_req_i(rd_req), .rd_ack_o(rd_ack),
    .rdata_o(rdata), .irq_num_o(irq_num), .irq_o(irq), .op_type_o(op_type),
    .locality_o(locality), .buf_len_o(buf_len), .exec_o(exec_s), .abort_o(abort_s),
    .complete_i(complete), .rsp_len_i(rsp_len), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_wr_o(ram_wr), .ram_rdata_i(ram_rdata));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ram_wr) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
    if (exec_s) begin
      exec_cnt <= exec_cnt + 1;
      cap_op   <= op_type;
      cap_loc  <= locality;
      cap_len  <= buf_len;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_req = 1'b1;
    do @(negedge clk); while (!wr_ack);
    wr_req = 1'b0;
    do @(negedge clk); while (wr_ack);
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    do @(negedge clk); while (!rd_ack);
    d = rdata;
    rd_req = 1'b0;
    do @(negedge clk); while (rd_ack);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] e);
    logic [7:0] v;
    bus_rd(a, v);
    chk(req, int'(v), int'(e));
  endtask

  task automatic pulse_complete(input logic [CW-1:0] len);
    @(negedge clk);
    rsp_len = len; complete = 1'b1;
    repeat (3) @(negedge clk);
    complete = 1'b0;
    @(negedge clk);
  endtask

  // {req, write, addr, data, expected}
  localparam int NV = 35;
  localparam logic [36:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0, 16'h0000, 8'h00, 8'h80},  // R1
    {4'd5, 1'b0, 16'h0018, 8'h00, 8'hFF},  // R5
    {4'd4, 1'b1, 16'h0000, 8'h02, 8'h00},
    {4'd4, 1'b0, 16'h0000, 8'h00, 8'hA0},  // R4
    {4'd4, 1'b0, 16'h1000, 8'h00, 8'h80},
    {4'd4, 1'b1, 16'h1000, 8'h02, 8'h00},
    {4'd4, 1'b0, 16'h1000, 8'h00, 8'h80},  // R4 second claim ignored
    {4'd5, 1'b1, 16'h1018, 8'h40, 8'h00},
    {4'd5, 1'b0, 16'h0018, 8'h00, 8'h80},  // R5 dropped, R6 idle
    {4'd5, 1'b0, 16'h1018, 8'h00, 8'hFF},
    {4'd6, 1'b1, 16'h0018, 8'h40, 8'h00},
    {4'd6, 1'b0, 16'h0018, 8'h00, 8'hC8},  // R6
    {4'd7, 1'b1, 16'h0024, 8'h80, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h01, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h00, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h00, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h00, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h0A, 8'h00},
    {4'd7, 1'b0, 16'h0018, 8'h00, 8'h88},  // R7 six of ten
    {4'd7, 1'b1, 16'h0024, 8'h00, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h00, 8'h00},
    {4'd7, 1'b1, 16'h0024, 8'h01, 8'h00},
    {4'd7, 1'b0, 16'h0018, 8'h00, 8'h88},
    {4'd7, 1'b1, 16'h0024, 8'h44, 8'h00},
    {4'd7, 1'b0, 16'h0018, 8'h00, 8'h80},  // R7 size reached
    {4'd10, 1'b0, 16'h0024, 8'h00, 8'hFF}, // R10 no response yet
    {4'd3, 1'b0, 16'h0025, 8'h00, 8'hFF},  // R3
    {4'd3, 1'b1, 16'h0025, 8'hFF, 8'h00},
    {4'd3, 1'b1, 16'h0019, 8'hFF, 8'h00},
    {4'd3, 1'b0, 16'h0018, 8'h00, 8'h80},  // R3 no effect
    {4'd11, 1'b1, 16'h0008, 8'h81, 8'h00},
    {4'd11, 1'b0, 16'h0008, 8'h00, 8'h81}, // R11
    {4'd11, 1'b1, 16'h000C, 8'h05, 8'h00},
    {4'd11, 1'b0, 16'h000C, 8'h00, 8'h05},
    {4'd11, 1'b0, 16'h1008, 8'h00, 8'h81}  // R11 any locality reads
  };

  initial begin
    logic [7:0] v;
    int bad;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 op_type", int'(op_type), 0);
    chk("R1 strobes", int'({exec_s, abort_s, irq, wr_ack, rd_ack}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) bus_wr(VEC[i][31:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][31:16], v);
        checks = checks + 1;
        if (v !== VEC[i][7:0]) begin
          errors = errors + 1;
          $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                   VEC[i][36:33], i, v, VEC[i][7:0]);
        end
      end
    end
    chk("R11 irq_num", int'(irq_num), 5);

    // R2 handshake timing
    @(negedge clk);
    addr = 16'h0000; rd_req = 1'b1;
    @(negedge clk);
    chk("R2 ack after one edge", int'(rd_ack), 1);
    chk("R2 data with ack", int'(rdata), 8'hA0);
    repeat (3) @(negedge clk);
    chk("R2 ack held", int'({rd_ack, rdata}), int'({1'b1, 8'hA0}));
    rd_req = 1'b0;
    @(negedge clk);
    chk("R2 ack drop", int'(rd_ack), 0);

    // R8 go
    bus_wr(16'h0018, 8'h20);
    @(negedge clk);
    chk("R8 exec pulses", exec_cnt, 1);
    chk("R8 op/loc/len", int'({cap_op, cap_loc, cap_len}), int'({4'd1, 3'd0, 6'd10}));
    rd_chk("R8 sts in exec", 16'h0018, 8'h80);
    bad = 0;
    if (mem[0] !== 8'h80 || mem[1] !== 8'h01 || mem[5] !== 8'h0A || mem[9] !== 8'h44) bad = 1;
    chk("R7 buffer contents", bad, 0);
    rd_chk("R10 fifo in exec", 16'h0024, 8'hFF);

    // R10 completion and response stream
    mem[0] = 8'hC0; mem[1] = 8'hC1; mem[2] = 8'hC2; mem[3] = 8'hC3;
    pulse_complete(6'd4);
    chk("R10 op cleared", int'(op_type), 0);
    chk("R11 irq raised", int'(irq), 1);
    rd_chk("R10 dataAvail", 16'h0018, 8'h90);
    for (int i = 0; i < 4; i++) rd_chk("R10 response byte", 16'h0024, 8'hC0 + 8'(i));
    rd_chk("R10 dataAvail cleared", 16'h0018, 8'h80);
    rd_chk("R10 fifo drained", 16'h0024, 8'hFF);
    rd_chk("R11 status set", 16'h0010, 8'h01);
    bus_wr(16'h1010, 8'h01);
    chk("R11 non-owner clear dropped", int'(irq), 1);
    bus_wr(16'h0010, 8'h01);
    chk("R11 irq cleared", int'(irq), 0);

    // R12 back to ready, R13 overflow
    bus_wr(16'h0018, 8'h40);
    rd_chk("R12 ready from completion", 16'h0018, 8'hC8);
    for (int i = 0; i < 34; i++) bus_wr(16'h0024, 8'(i));
    rd_chk("R7 expect at full", 16'h0018, 8'h88);
    bus_wr(16'h0018, 8'h20);
    @(negedge clk);
    chk("R13 len capped", int'(cap_len), 32);
    chk("R13 last stored", int'(mem[31]), 31);

    // R9 abort
    bus_wr(16'h0018, 8'h40);
    chk("R9 abort raised", int'(abort_s), 1);
    pulse_complete(6'd0);
    chk("R9 abort cleared", int'(abort_s), 0);
    rd_chk("R10 empty response", 16'h0018, 8'h80);

    // R4 release and R3 out-of-range locality
    bus_wr(16'h0000, 8'h20);
    rd_chk("R4 released", 16'h0000, 8'h80);
    bus_wr(16'h1000, 8'h02);
    rd_chk("R4 loc1 owner", 16'h1000, 8'hA0);
    rd_chk("R4 loc0 not owner", 16'h0000, 8'h80);
    bus_wr(16'h5000, 8'h20);
    rd_chk("R3 locality 5", 16'h5000, 8'hFF);
    rd_chk("R3 loc1 kept", 16'h1000, 8'hA0);
    rd_chk("R3 bit15 set", 16'h8000, 8'hFF);

    finish_run();
  end
endmodule